// File: doc/BRIEF.md
# Stack-Oriented Address Register Unit

This block is the address-arithmetic engine of a microprogrammed machine that keeps its stack in RAM. It holds three address registers with fixed roles: a program counter, a stack pointer and an operand-address register. On every clock a 4-bit operation code picks one of sixteen operations. The operations cover increment, decrement, register copy, load from the input bus, relative offset addition, an idle code and a hold code. Every operation completes in one cycle.

Each operation also selects one register for presentation. Two address ports show it. The registered port shows the value the register holds now. The transparent port shows the value the register will hold after the coming edge. A post-increment therefore presents the old address while it advances, and a pre-decrement presents the already decremented address. This gives a one-cycle push (pre-decrement) and a one-cycle pop (post-increment). Each port has its own enable and is high-impedance when that enable is low.

The datapath is a chain of 4-bit adder slices joined by a ripple carry. The width is a parameter that must be a multiple of four.

Top module: `addr_reg_unit`

## Requirements
- R1: An active-high reset, sampled on the rising clock edge, clears the program counter, the stack pointer and the operand register to zero.
- R2: Codes 0, 1 and 2 post-increment the program counter, the stack pointer and the operand register respectively. The registered port shows the old value and the register gains one at the edge.
- R3: Codes 3, 4 and 5 pre-decrement the program counter, the stack pointer and the operand register respectively. The transparent port shows the value minus one, and the register takes that value at the edge.
- R4: For codes 0 to 5, a low carry-in leaves the register unchanged and drives carry-out low.
- R5: Code 6 copies the program counter into the operand register. Code 7 copies the stack pointer into the operand register. Code 8 copies the operand register into the stack pointer.
- R6: Codes 9, 10 and 11 load the program counter, the stack pointer and the operand register from the data bus respectively.
- R7: Code 12 sets the operand register to stack pointer + data + carry-in. Code 13 sets the operand register to program counter + data + carry-in.
- R8: Carry-out is the carry from the top slice for increment and relative add. For decrement it is the borrow, which is high when a zero register is decremented with carry-in high. It is low for codes 6 to 11, 14 and 15.
- R9: The presented register is as follows. Codes 0/3/9/15 present the program counter. Codes 1/4/8/10/14 present the stack pointer. Codes 2/5/6/7/11/12/13 present the operand register.
- R10: The registered port shows the presented register's current value. The transparent port shows the value it will hold after the next edge.
- R11: Each port is all-Z while its own enable is low. Disabling the ports does not stop register updates.
- R12: Code 14 (idle) and code 15 (hold) change no register. Under code 15 both ports show the program counter.
- R13: Carries ripple between 4-bit slices. Incrementing 0x000F gives 0x0010, and incrementing 0xFFFF gives 0x0000 with carry-out high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| din | input | WIDTH | Load data or relative offset |
| cin | input | 1 | Increment/decrement enable and carry into relative add |
| oe_lat | input | 1 | Enable for the registered address port |
| oe_thru | input | 1 | Enable for the transparent address port |
| cout | output | 1 | Carry or borrow from the top slice |
| addr_lat | output | WIDTH | Registered address port, Z when disabled |
| addr_thru | output | WIDTH | Transparent address port, Z when disabled |

## Verification
The bench targets the cases where the two ports must differ. Post-increment on the registered port must show the old value. Pre-decrement on the transparent port must show the new value. A design that swapped the ports would present every push and pop address off by one.

Carry is driven across slice boundaries (0x000F and 0xFFFF) and borrow out of zero. A broken chain would give 0x0000 for 0x000F + 1 or lose carry-out. Carry-in held low must freeze inc/dec. The idle and hold codes must change nothing, and hold must show the program counter on both ports. Both ports are disabled while an increment runs, and the result is then read back. A design that gated the write with the enable would lose that update.

// File: rtl/aru_pkg.sv
package aru_pkg;

    typedef enum logic [3:0] {
        OP_INC_PC   = 4'd0,
        OP_INC_SP   = 4'd1,
        OP_INC_OA   = 4'd2,
        OP_DEC_PC   = 4'd3,
        OP_DEC_SP   = 4'd4,
        OP_DEC_OA   = 4'd5,
        OP_PC_TO_OA = 4'd6,
        OP_SP_TO_OA = 4'd7,
        OP_OA_TO_SP = 4'd8,
        OP_LD_PC    = 4'd9,
        OP_LD_SP    = 4'd10,
        OP_LD_OA    = 4'd11,
        OP_REL_SP   = 4'd12,
        OP_REL_PC   = 4'd13,
        OP_IDLE     = 4'd14,
        OP_HOLD     = 4'd15
    } aru_op_e;

    typedef enum logic [1:0] {
        IDX_PC = 2'd0,
        IDX_SP = 2'd1,
        IDX_OA = 2'd2
    } reg_idx_e;

    typedef enum logic [2:0] {
        K_INC,
        K_DEC,
        K_ADD,
        K_COPY,
        K_LOAD,
        K_NONE
    } op_kind_e;

    typedef struct packed {
        reg_idx_e target;
        reg_idx_e src;
        op_kind_e kind;
        logic     write;
    } aru_ctl_t;

endpackage

// File: rtl/aru_nibble_add.sv
module aru_nibble_add (
    input  logic [3:0] a,
    input  logic [3:0] b,
    input  logic       ci,
    output logic [3:0] s,
    output logic       co
);
    logic [4:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b} + {4'b0, ci};
        s    = wide[3:0];
        co   = wide[4];
    end
endmodule

// File: rtl/aru_carry_chain.sv
module aru_carry_chain #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             ci,
    output logic [WIDTH-1:0] s,
    output logic             co
);
    localparam int NSLICE = WIDTH / 4;

    logic [NSLICE:0] carry;
    assign carry[0] = ci;
    assign co       = carry[NSLICE];

    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        aru_nibble_add u_nib (
            .a  (a[4*g +: 4]),
            .b  (b[4*g +: 4]),
            .ci (carry[g]),
            .s  (s[4*g +: 4]),
            .co (carry[g+1])
        );
    end
endmodule

// File: rtl/aru_decode.sv
module aru_decode
    import aru_pkg::*;
(
    input  logic [3:0] op,
    output aru_ctl_t   ctl
);
    always_comb begin
        ctl = '{target: IDX_PC, src: IDX_PC, kind: K_NONE, write: 1'b0};
        unique case (aru_op_e'(op))
            OP_INC_PC:   ctl = '{IDX_PC, IDX_PC, K_INC,  1'b1};
            OP_INC_SP:   ctl = '{IDX_SP, IDX_SP, K_INC,  1'b1};
            OP_INC_OA:   ctl = '{IDX_OA, IDX_OA, K_INC,  1'b1};
            OP_DEC_PC:   ctl = '{IDX_PC, IDX_PC, K_DEC,  1'b1};
            OP_DEC_SP:   ctl = '{IDX_SP, IDX_SP, K_DEC,  1'b1};
            OP_DEC_OA:   ctl = '{IDX_OA, IDX_OA, K_DEC,  1'b1};
            OP_PC_TO_OA: ctl = '{IDX_OA, IDX_PC, K_COPY, 1'b1};
            OP_SP_TO_OA: ctl = '{IDX_OA, IDX_SP, K_COPY, 1'b1};
            OP_OA_TO_SP: ctl = '{IDX_SP, IDX_OA, K_COPY, 1'b1};
            OP_LD_PC:    ctl = '{IDX_PC, IDX_PC, K_LOAD, 1'b1};
            OP_LD_SP:    ctl = '{IDX_SP, IDX_SP, K_LOAD, 1'b1};
            OP_LD_OA:    ctl = '{IDX_OA, IDX_OA, K_LOAD, 1'b1};
            OP_REL_SP:   ctl = '{IDX_OA, IDX_SP, K_ADD,  1'b1};
            OP_REL_PC:   ctl = '{IDX_OA, IDX_PC, K_ADD,  1'b1};
            OP_IDLE:     ctl = '{IDX_SP, IDX_SP, K_NONE, 1'b0};
            OP_HOLD:     ctl = '{IDX_PC, IDX_PC, K_NONE, 1'b0};
            default:     ctl = '{IDX_PC, IDX_PC, K_NONE, 1'b0};
        endcase
    end
endmodule

// File: rtl/addr_reg_unit.sv
module addr_reg_unit
    import aru_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] din,
    input  logic             cin,
    input  logic             oe_lat,
    input  logic             oe_thru,
    output logic             cout,
    output logic [WIDTH-1:0] addr_lat,
    output logic [WIDTH-1:0] addr_thru
);
    if (WIDTH % 4 != 0 || WIDTH < 4) begin : g_bad_width
        $error("addr_reg_unit: WIDTH must be a positive multiple of 4");
    end

    aru_ctl_t         ctl;
    logic [WIDTH-1:0] regs [0:2];
    logic [WIDTH-1:0] src_val, cur_val, opnd_b, sum, new_val;
    logic             chain_ci, chain_co;
    logic [1:0]       sel_idx;

    aru_decode u_dec (
        .op  (op),
        .ctl (ctl)
    );

    assign src_val = regs[ctl.src];
    assign cur_val = regs[ctl.target];
    assign sel_idx = ctl.target;

    // Operand steering into the slice chain
    always_comb begin
        opnd_b   = '0;
        chain_ci = 1'b0;
        unique case (ctl.kind)
            K_INC:   chain_ci = cin;
            K_DEC:   opnd_b   = {WIDTH{cin}};
            K_ADD: begin
                opnd_b   = din;
                chain_ci = cin;
            end
            default: ;
        endcase
    end

    aru_carry_chain #(.WIDTH(WIDTH)) u_chain (
        .a  (src_val),
        .b  (opnd_b),
        .ci (chain_ci),
        .s  (sum),
        .co (chain_co)
    );

    // Next value of the presented register and carry-out
    always_comb begin
        new_val = cur_val;
        cout    = 1'b0;
        unique case (ctl.kind)
            K_INC, K_ADD: begin
                new_val = sum;
                cout    = chain_co;
            end
            K_DEC: begin
                new_val = sum;
                cout    = cin & ~chain_co;
            end
            K_COPY:  new_val = src_val;
            K_LOAD:  new_val = din;
            default: new_val = cur_val;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs[0] <= '0;
            regs[1] <= '0;
            regs[2] <= '0;
        end else if (ctl.write) begin
            regs[ctl.target] <= new_val;
        end
    end

    assign addr_lat  = oe_lat  ? cur_val : {WIDTH{1'bz}};
    assign addr_thru = oe_thru ? new_val : {WIDTH{1'bz}};

    assert_postinc_R2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INC_PC && cin) |=> regs[0] == $past(regs[0]) + WIDTH'(1));

    assert_predec_R3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_DEC_SP && cin) |=> regs[1] == $past(regs[1]) - WIDTH'(1));

    assert_cin_off_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INC_OA && !cin) |=> $stable(regs[2]));

    assert_copy_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_OA_TO_SP) |=> regs[1] == $past(regs[2]));

    assert_load_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LD_PC) |=> regs[0] == $past(din));

    assert_cout_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        ((op >= 4'd6 && op <= 4'd11) || op >= 4'd14) |-> !cout);

    assert_transparent_R10: assert property (@(posedge clk) disable iff (rst)
        oe_thru |=> regs[$past(sel_idx)] == $past(addr_thru));

    assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IDLE || op == OP_HOLD)
        |=> ($stable(regs[0]) && $stable(regs[1]) && $stable(regs[2])));
endmodule

// File: tb/addr_reg_unit_bench.sv
module addr_reg_unit_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic [3:0]   op;
    logic [W-1:0] din;
    logic         cin, oe_lat, oe_thru;
    wire          cout;
    wire  [W-1:0] addr_lat, addr_thru;

    always #10 clk = ~clk;

    addr_reg_unit #(.WIDTH(W)) u_addr_reg_unit (
        .clk(clk), .rst(rst), .op(op), .din(din), .cin(cin),
        .oe_lat(oe_lat), .oe_thru(oe_thru), .cout(cout),
        .addr_lat(addr_lat), .addr_thru(addr_thru)
    );

    typedef struct {
        logic         skip;
        logic [W-1:0] e_lat;
        logic [W-1:0] e_thru;
        logic         e_cout;
        string        tag;
    } item_t;

    item_t        sb[$];
    logic [W-1:0] m [0:2];
    int           errors = 0;
    int           checks = 0;
    bit           done = 0;

    function automatic int pick(input int code);
        if (code <= 5) return code % 3;
        if (code == 9 || code == 15) return 0;
        if (code == 8 || code == 10 || code == 14) return 1;
        return 2;
    endfunction

    task automatic issue(input int code, input logic [W-1:0] d, input logic c,
                         input logic ol, input logic ot, input logic r, input string tag);
        item_t        it;
        int           s;
        logic [W-1:0] nv;
        logic [W:0]   wide;
        logic         co;
        @(posedge clk);
        #2;
        rst = r; op = 4'(code); din = d; cin = c; oe_lat = ol; oe_thru = ot;
        it.skip = r;
        it.tag  = tag;
        s  = pick(code);
        nv = m[s];
        co = 1'b0;
        if (code <= 2) begin
            wide = {1'b0, m[s]} + (W+1)'(c);
            nv = wide[W-1:0]; co = wide[W];
        end else if (code <= 5) begin
            nv = m[s] - W'(c);
            co = c && (m[s] == '0);
        end else if (code == 6) nv = m[0];
        else if (code == 7) nv = m[1];
        else if (code == 8) nv = m[2];
        else if (code <= 11) nv = d;
        else if (code <= 13) begin
            wide = {1'b0, m[code == 12 ? 1 : 0]} + {1'b0, d} + (W+1)'(c);
            nv = wide[W-1:0]; co = wide[W];
        end
        it.e_lat  = ol ? m[s] : {W{1'bz}};
        it.e_thru = ot ? nv   : {W{1'bz}};
        it.e_cout = co;
        if (r) begin
            m[0] = '0; m[1] = '0; m[2] = '0;
        end else if (code <= 13) begin
            m[s] = nv;
        end
        sb.push_back(it);
    endtask

    task automatic cmp(input string what, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: pops one expectation per cycle, mid-cycle
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            if (!it.skip) begin
                cmp("addr_lat",  it.tag, addr_lat,  it.e_lat);
                cmp("addr_thru", it.tag, addr_thru, it.e_thru);
                cmp("cout",      it.tag, W'(cout),  W'(it.e_cout));
            end
        end
    end

    initial begin
        rst = 1'b1; op = 4'd14; din = '0; cin = 1'b0; oe_lat = 1'b0; oe_thru = 1'b0;
        m[0] = '0; m[1] = '0; m[2] = '0;
        issue(14, 16'h0, 0, 0, 0, 1, "R1");
        issue(14, 16'h0, 0, 1, 1, 0, "R1 idle after reset");
        issue(15, 16'h0, 0, 1, 1, 0, "R1 hold after reset");
        issue(14, 16'h0, 0, 0, 0, 0, "R11 both disabled");
        issue(9,  16'h1234, 0, 1, 1, 0, "R6 load pc");
        issue(10, 16'h0100, 0, 1, 1, 0, "R6 load sp");
        issue(11, 16'hFFFF, 0, 1, 1, 0, "R6 load oa");
        issue(0,  16'h0, 1, 1, 1, 0, "R2 post-inc pc");
        issue(2,  16'h0, 1, 1, 1, 0, "R13 oa FFFF wrap");
        issue(5,  16'h0, 1, 1, 1, 0, "R8 borrow from zero");
        issue(4,  16'h0, 0, 1, 1, 0, "R4 dec sp cin low");
        issue(1,  16'h0, 0, 1, 1, 0, "R4 inc sp cin low");
        issue(3,  16'h0, 1, 1, 1, 0, "R3 pre-dec pc");
        issue(6,  16'h0, 0, 1, 1, 0, "R5 pc to oa");
        issue(7,  16'h0, 0, 1, 1, 0, "R5 sp to oa");
        issue(11, 16'h00F0, 0, 1, 1, 0, "R6 load oa");
        issue(8,  16'h0, 0, 1, 1, 0, "R5 oa to sp");
        issue(12, 16'h0010, 1, 1, 1, 0, "R7 sp relative");
        issue(13, 16'hEDCC, 0, 1, 1, 0, "R7 pc relative carry");
        issue(15, 16'hAAAA, 1, 1, 1, 0, "R12 hold shows pc");
        issue(14, 16'h5555, 1, 0, 1, 0, "R11 lat port off");
        issue(14, 16'h0, 0, 1, 0, 0, "R11 thru port off");
        issue(0,  16'h0, 1, 0, 0, 0, "R11 inc while disabled");
        issue(15, 16'h0, 0, 1, 1, 0, "R11 readback pc");
        issue(4,  16'h0, 1, 1, 1, 0, "R3 push sp");
        issue(1,  16'h0, 1, 1, 1, 0, "R2 pop sp");
        issue(10, 16'h000F, 0, 1, 1, 0, "R6 load sp");
        issue(1,  16'h0, 1, 1, 1, 0, "R13 slice carry 000F");
        issue(14, 16'h0, 0, 1, 1, 0, "R9 idle shows sp");
        issue(2,  16'h0, 1, 1, 1, 0, "R9 oa presented");
        issue(14, 16'h0, 0, 0, 0, 1, "R1");
        issue(15, 16'h0, 0, 1, 1, 0, "R1 pc cleared");
        issue(14, 16'h0, 0, 1, 1, 0, "R1 sp cleared");
        issue(2,  16'h0, 0, 1, 1, 0, "R1 oa cleared");
        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule